// File: doc/BRIEF.md
# Event-Reloaded Seconds/Minutes Watchdog

A down-counting watchdog set up through four byte-wide registers on a simple synchronous register port. Software writes a reload value; a nonzero value starts the counter and writing it again acts as a keepalive. A value of zero stops it. The counter steps once per second, or once per minute, driven by an external 1 Hz tick. A built-in divide-by-60 prescaler provides the minute rate.

Four peripheral event inputs can also act as keepalives. When enabled, each one restores the counter to the last programmed value. The events are a game-port read, an infrared-receiver interrupt, a keyboard interrupt and a mouse interrupt. The infrared event takes effect only after a configurable settling delay.

When the counter runs out, a sticky expiry flag is set. Each enabled reset output fires for exactly one clock. A software force bit produces the same expiry at once. The counter is 16 bits wide by default and can be built 8 bits wide.

Top module: `wdg_evt_timer`

## Requirements
- R1: After reset every register reads 0x00, the counter is stopped at 0 and all pulse outputs are low.
- R2: Register addresses are control 0x71, config 0x72, count low 0x73 and count high 0x74. Control bits are: 7 IR reload enable, 6 mouse reload enable, 5 keyboard reload enable, 4 game-port reload enable, 1 force (write-only, reads 0) and 0 expiry flag. Config reads back exactly as written.
- R3: With CNT_W=16, a write to 0x74 only stages the high byte. A write to 0x73 latches {staged high, written low} as the reload value and loads the counter. With CNT_W=8, writes to 0x74 are ignored and 0x74 reads 0. Reads of 0x73 and 0x74 return the live count.
- R4: With config bit 7 set, the counter decrements on each tick. With it clear, the counter decrements on every 60th tick. The 60-tick prescaler is cleared by every load, reload or force.
- R5: A nonzero count written to 0x73 starts or reloads the counter. Writing zero stops it: the count stays 0 and no expiry occurs.
- R6: While the counter is running, a game-port, keyboard or mouse event whose enable bit is set restores the reload value on the next clock. Disabled events, and events while the counter is stopped, have no effect.
- R7: An enabled IR event reloads the running counter exactly IR_RELOAD_DLY clocks after the event is sampled. Before that the counter keeps its value.
- R8: When a tick takes the counter from 1 to 0, the expiry flag is set. It stays set until a control write with bit 0 clear. A control write with bit 0 set leaves it unchanged.
- R9: On expiry, kbd_rst_o (config bit 6), tmo_o (config bit 5) and pwr_rst_o (config bit 4) each pulse high for exactly one clock if their bit is set. A cleared bit keeps its output low, but the flag is still set.
- R10: A control write with bit 1 set expires the block on that clock edge: the count becomes 0, the flag is set and the enabled outputs pulse. Setting the flag takes priority over the clear carried by the same write.
- R11: irq_route_o always equals config bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick_1hz | input | 1 | One-clock pulse per second |
| evt_game | input | 1 | Game-port read event |
| evt_ir | input | 1 | IR receiver interrupt event |
| evt_kbd | input | 1 | Keyboard interrupt event |
| evt_mouse | input | 1 | Mouse interrupt event |
| kbd_rst_o | output | 1 | Keyboard-reset pulse on expiry |
| tmo_o | output | 1 | Timeout pulse on expiry |
| pwr_rst_o | output | 1 | Power-good reset pulse on expiry |
| irq_route_o | output | 4 | Selected interrupt line |

## Verification
The bench checks that the prescaler really restarts on a keepalive in minute mode. A design that kept the partial count would step after 30 ticks instead of 60. It checks that a high-byte write alone leaves the count untouched, which catches a design that reloads on either byte. The IR reload is sampled one clock before and exactly at its due edge to expose an off-by-one delay. Expiry is checked for single-cycle pulses, a flag that survives writes with bit 0 set, outputs masked by their enables, and a zero write that must never expire.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam logic [7:0] ADR_CTRL   = 8'h71;
   localparam logic [7:0] ADR_CFG    = 8'h72;
   localparam logic [7:0] ADR_CNT_LO = 8'h73;
   localparam logic [7:0] ADR_CNT_HI = 8'h74;

   localparam int CTRL_FORCE_BIT = 1;
   localparam int CTRL_FLAG_BIT  = 0;
   localparam int CFG_SEC_BIT    = 7;
   localparam int CFG_KRST_BIT   = 6;
   localparam int CFG_TMO_BIT    = 5;
   localparam int CFG_PWR_BIT    = 4;

   // reload-source enables, packed in control-register order 7..4
   typedef struct packed {
      logic ir;
      logic mouse;
      logic kbd;
      logic game;
   } evt_en_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
   parameter int TICKS_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sec_mode,
   input  logic clr,
   output logic step
);
   localparam int PW = $clog2(TICKS_PER_MIN);
   localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

   generate
      if (TICKS_PER_MIN < 2) begin : g_bad
         $error("TICKS_PER_MIN must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pre <= '0;
      else if (clr)               pre <= '0;
      else if (tick && !sec_mode) pre <= (pre == LAST) ? '0 : pre + 1'b1;
   end

   assign step = tick && (sec_mode || pre == LAST);

   // R4: prescaler never leaves its 0..TICKS_PER_MIN-1 range
   p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pre <= LAST);
endmodule

// File: rtl/wdg_evt_reload.sv
module wdg_evt_reload import wdg_pkg::*; #(
   parameter int IR_RELOAD_DLY = 250000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  evt_en_t en,
   input  logic    running,
   input  logic    evt_game,
   input  logic    evt_ir,
   input  logic    evt_kbd,
   input  logic    evt_mouse,
   output logic    imm_fire,
   output logic    ir_fire
);
   localparam int DW = $clog2(IR_RELOAD_DLY + 1);

   generate
      if (IR_RELOAD_DLY < 1) begin : g_bad
         $error("IR_RELOAD_DLY must be at least 1");
      end
   endgenerate

   logic          pend;
   logic [DW-1:0] dly;

   assign imm_fire = (evt_game && en.game) || (evt_kbd && en.kbd) ||
                     (evt_mouse && en.mouse);
   assign ir_fire  = pend && (dly == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         dly  <= '0;
      end else if (ir_fire) begin
         pend <= 1'b0;
      end else if (pend) begin
         dly <= dly - 1'b1;
      end else if (evt_ir && en.ir && running) begin
         pend <= 1'b1;
         dly  <= DW'(IR_RELOAD_DLY - 1);
      end
   end

   generate
      if (IR_RELOAD_DLY > 1) begin : g_chk
         // R7: the IR reload never lands on the clock right after its event
         p_ir_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend) |-> !ir_fire);
      end
   endgenerate
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs import wdg_pkg::*; #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             flag_set,
   output evt_en_t          en,
   output logic [7:0]       cfg,
   output logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] reload_val,
   output logic             flag,
   output logic [7:0]       rdata
);
   logic [7:0]  hi_stage;
   logic [15:0] cnt_ext;
   logic        wr_ctrl, wr_cfg, wr_lo;

   assign wr_ctrl = we && addr == ADR_CTRL;
   assign wr_cfg  = we && addr == ADR_CFG;
   assign wr_lo   = we && addr == ADR_CNT_LO;

   generate
      if (CNT_W == 16) begin : g_w16
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        hi_stage <= '0;
            else if (we && addr == ADR_CNT_HI) hi_stage <= wdata;
         end
      end else if (CNT_W == 8) begin : g_w8
         assign hi_stage = '0;
      end else begin : g_bad
         assign hi_stage = '0;
         $error("CNT_W must be 8 or 16");
      end
   endgenerate

   assign load_val = CNT_W'({hi_stage, wdata});
   assign cnt_ext  = 16'(cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= '0;
         cfg        <= '0;
         reload_val <= '0;
         flag       <= 1'b0;
      end else begin
         if (wr_ctrl) en <= evt_en_t'(wdata[7:4]);
         if (wr_cfg)  cfg <= wdata;
         if (wr_lo)   reload_val <= load_val;
         if (flag_set)                               flag <= 1'b1;
         else if (wr_ctrl && !wdata[CTRL_FLAG_BIT])  flag <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         ADR_CTRL:   rdata = {en, 3'b000, flag};
         ADR_CFG:    rdata = cfg;
         ADR_CNT_LO: rdata = cnt_ext[7:0];
         ADR_CNT_HI: rdata = cnt_ext[15:8];
         default:    rdata = '0;
      endcase
   end

   // R8: the expiry flag only drops on a control write
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !wr_ctrl |=> flag);
endmodule

// File: rtl/wdg_evt_timer.sv
module wdg_evt_timer import wdg_pkg::*; #(
   parameter int CNT_W         = 16,
   parameter int TICKS_PER_MIN = 60,
   parameter int IR_RELOAD_DLY = 250000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       tick_1hz,
   input  logic       evt_game,
   input  logic       evt_ir,
   input  logic       evt_kbd,
   input  logic       evt_mouse,
   output logic       kbd_rst_o,
   output logic       tmo_o,
   output logic       pwr_rst_o,
   output logic [3:0] irq_route_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   evt_en_t          en;
   logic [7:0]       cfg;
   logic [CNT_W-1:0] cnt, load_val, reload_val;
   logic             flag, running, wr_lo, force_x;
   logic             step, imm_fire, ir_fire, evt_reload, expire;

   assign wr_lo      = reg_we && reg_addr == ADR_CNT_LO;
   assign force_x    = reg_we && reg_addr == ADR_CTRL && reg_wdata[CTRL_FORCE_BIT];
   assign running    = cnt != '0;
   assign evt_reload = running && (imm_fire || ir_fire);
   assign expire     = force_x ||
                       (!wr_lo && !evt_reload && running && step && cnt == ONE);

   wdg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .cnt(cnt), .flag_set(expire), .en(en), .cfg(cfg), .load_val(load_val),
      .reload_val(reload_val), .flag(flag), .rdata(reg_rdata));

   wdg_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .sec_mode(cfg[CFG_SEC_BIT]),
      .clr(wr_lo || evt_reload || force_x), .step(step));

   wdg_evt_reload #(.IR_RELOAD_DLY(IR_RELOAD_DLY)) u_evt (
      .clk(clk), .rst_n(rst_n), .en(en), .running(running),
      .evt_game(evt_game), .evt_ir(evt_ir), .evt_kbd(evt_kbd),
      .evt_mouse(evt_mouse), .imm_fire(imm_fire), .ir_fire(ir_fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (wr_lo)              cnt <= load_val;
      else if (force_x)            cnt <= '0;
      else if (evt_reload)         cnt <= reload_val;
      else if (running && step)    cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kbd_rst_o <= 1'b0;
         tmo_o     <= 1'b0;
         pwr_rst_o <= 1'b0;
      end else begin
         kbd_rst_o <= expire && cfg[CFG_KRST_BIT];
         tmo_o     <= expire && cfg[CFG_TMO_BIT];
         pwr_rst_o <= expire && cfg[CFG_PWR_BIT];
      end
   end

   assign irq_route_o = cfg[3:0];

   // R5: a stopped counter stays stopped until the low byte is written
   p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !wr_lo |=> cnt == '0);
   // R9: any reset pulse comes with the expiry flag set
   p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kbd_rst_o || tmo_o || pwr_rst_o) |-> flag);
   // R10: a force write leaves the counter at zero and the flag set
   p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
      force_x |=> cnt == '0 && flag);
endmodule

// File: tb/test_wdg_evt_timer.sv
module test_wdg_evt_timer;
   localparam int DLY = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic we = 1'b0, tick = 1'b0;
   logic ev_gp = 1'b0, ev_ir = 1'b0, ev_kb = 1'b0, ev_ms = 1'b0;
   logic [7:0] addr = 8'h00, wdata = 8'h00;
   logic [7:0] rdata, rdata8;
   logic kbrst, tmo, pwrst, kbrst8, tmo8, pwrst8;
   logic [3:0] route, route8;
   int n_chk = 0, n_fail = 0, cyc = 0;

   always #10 clk = ~clk;

   wdg_evt_timer #(.CNT_W(16), .TICKS_PER_MIN(60), .IR_RELOAD_DLY(DLY)) i_wdg_evt_timer (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .tick_1hz(tick), .evt_game(ev_gp), .evt_ir(ev_ir),
      .evt_kbd(ev_kb), .evt_mouse(ev_ms), .kbd_rst_o(kbrst), .tmo_o(tmo),
      .pwr_rst_o(pwrst), .irq_route_o(route));

   wdg_evt_timer #(.CNT_W(8), .TICKS_PER_MIN(60), .IR_RELOAD_DLY(DLY)) i_wdg_evt_timer_w8 (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata8), .tick_1hz(tick), .evt_game(ev_gp), .evt_ir(ev_ir),
      .evt_kbd(ev_kb), .evt_mouse(ev_ms), .kbd_rst_o(kbrst8), .tmo_o(tmo8),
      .pwr_rst_o(pwrst8), .irq_route_o(route8));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic rd_cnt(output logic [15:0] c);
      logic [7:0] lo, hi;
      rd(8'h73, lo); rd(8'h74, hi);
      c = {hi, lo};
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d; logic [15:0] c;
      rd(8'h71, d); chk("R1 ctrl", 16'(d), 16'h00);
      rd(8'h72, d); chk("R1 cfg", 16'(d), 16'h00);
      rd_cnt(c);    chk("R1 count", c, 16'h0000);
      chk("R1 pulses", {13'b0, kbrst, tmo, pwrst}, 16'h0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(8'h72, 8'h5A); rd(8'h72, d); chk("R2 cfg readback", 16'(d), 16'h5A);
      chk("R11 irq route", 16'(route), 16'hA);
      wr(8'h71, 8'hF0); rd(8'h71, d); chk("R2 ctrl enables", 16'(d), 16'hF0);
      wr(8'h71, 8'h00);
   endtask

   task automatic t_seconds();
      logic [15:0] c;
      wr(8'h72, 8'h80);
      wr(8'h74, 8'h01); wr(8'h73, 8'h03);
      rd_cnt(c); chk("R3 16-bit load", c, 16'h0103);
      ticks(1);  rd_cnt(c); chk("R4 seconds step", c, 16'h0102);
      wr(8'h74, 8'h00); rd_cnt(c); chk("R3 high byte only staged", c, 16'h0102);
      wr(8'h73, 8'h04); rd_cnt(c); chk("R5 reload by rewrite", c, 16'h0004);
   endtask

   task automatic t_minutes();
      logic [15:0] c;
      wr(8'h72, 8'h00); wr(8'h71, 8'h10);
      wr(8'h74, 8'h00); wr(8'h73, 8'h02);
      ticks(59); rd_cnt(c); chk("R4 minute not yet", c, 16'h0002);
      ticks(1);  rd_cnt(c); chk("R4 minute step", c, 16'h0001);
      ticks(30);
      ev_gp = 1'b1; @(negedge clk); ev_gp = 1'b0;
      rd_cnt(c); chk("R6 game reload in minute mode", c, 16'h0002);
      ticks(59); rd_cnt(c); chk("R4 prescaler cleared by reload", c, 16'h0002);
      ticks(1);  rd_cnt(c); chk("R4 step after full minute", c, 16'h0001);
      wr(8'h71, 8'h00); wr(8'h73, 8'h00);
   endtask

   task automatic t_stop();
      logic [15:0] c; logic [7:0] d;
      wr(8'h72, 8'hF0); wr(8'h73, 8'h00);
      for (int i = 0; i < 4; i++) begin
         ticks(1);
         chk("R5 no pulse when stopped", {13'b0, kbrst, tmo, pwrst}, 16'h0);
      end
      rd_cnt(c); chk("R5 stays stopped", c, 16'h0000);
      rd(8'h71, d); chk("R5 no expiry flag", 16'(d[0]), 16'h0);
   endtask

   task automatic t_events();
      logic [15:0] c;
      wr(8'h72, 8'h80); wr(8'h71, 8'h70); wr(8'h73, 8'h05);
      ticks(2);
      ev_gp = 1'b1; @(negedge clk); ev_gp = 1'b0;
      rd_cnt(c); chk("R6 game reload", c, 16'h0005);
      ticks(1);
      ev_kb = 1'b1; @(negedge clk); ev_kb = 1'b0;
      rd_cnt(c); chk("R6 keyboard reload", c, 16'h0005);
      ticks(1);
      ev_ms = 1'b1; @(negedge clk); ev_ms = 1'b0;
      rd_cnt(c); chk("R6 mouse reload", c, 16'h0005);
      ticks(1);
      ev_ir = 1'b1; @(negedge clk); ev_ir = 1'b0;
      idle(DLY + 4); rd_cnt(c); chk("R6 disabled IR ignored", c, 16'h0004);
      wr(8'h71, 8'h00);
      ev_gp = 1'b1; @(negedge clk); ev_gp = 1'b0;
      rd_cnt(c); chk("R6 disabled game ignored", c, 16'h0004);
      wr(8'h73, 8'h00); wr(8'h71, 8'h10);
      ev_gp = 1'b1; @(negedge clk); ev_gp = 1'b0;
      rd_cnt(c); chk("R6 no restart when stopped", c, 16'h0000);
      wr(8'h71, 8'h00);
   endtask

   task automatic t_ir();
      logic [15:0] c;
      wr(8'h72, 8'h80); wr(8'h71, 8'h80); wr(8'h73, 8'h05);
      ticks(2);
      ev_ir = 1'b1; @(negedge clk); ev_ir = 1'b0;
      idle(DLY - 1); rd_cnt(c); chk("R7 IR not early", c, 16'h0003);
      idle(1);       rd_cnt(c); chk("R7 IR reload on time", c, 16'h0005);
      wr(8'h71, 8'h00); wr(8'h73, 8'h00);
   endtask

   task automatic t_expiry();
      logic [7:0] d; logic [15:0] c;
      wr(8'h72, 8'hE0); wr(8'h73, 8'h02);
      ticks(1);
      chk("R9 no pulse before zero", {13'b0, kbrst, tmo, pwrst}, 16'h0);
      ticks(1);
      chk("R9 enabled pulses", {13'b0, kbrst, tmo, pwrst}, 16'b110);
      rd(8'h71, d); chk("R8 flag set", 16'(d), 16'h01);
      idle(1);
      chk("R9 pulse one cycle", {13'b0, kbrst, tmo, pwrst}, 16'h0);
      ticks(3); rd_cnt(c); chk("R8 stays at zero", c, 16'h0000);
      wr(8'h71, 8'h01); rd(8'h71, d); chk("R8 flag kept by bit0=1", 16'(d), 16'h01);
      wr(8'h71, 8'h00); rd(8'h71, d); chk("R8 flag cleared", 16'(d), 16'h00);
      wr(8'h72, 8'h80); wr(8'h73, 8'h01);
      ticks(1);
      chk("R9 masked outputs", {13'b0, kbrst, tmo, pwrst}, 16'h0);
      rd(8'h71, d); chk("R9 flag without outputs", 16'(d), 16'h01);
      wr(8'h71, 8'h00);
   endtask

   task automatic t_force();
      logic [7:0] d; logic [15:0] c;
      wr(8'h72, 8'h90); wr(8'h73, 8'h09);
      wr(8'h71, 8'h02);
      chk("R10 force pulse", {13'b0, kbrst, tmo, pwrst}, 16'b001);
      rd_cnt(c); chk("R10 force zeroes count", c, 16'h0000);
      rd(8'h71, d); chk("R10 flag set, force reads 0", 16'(d), 16'h01);
      wr(8'h71, 8'h00);
   endtask

   task automatic t_w8();
      logic [7:0] lo, hi;
      wr(8'h74, 8'h12); wr(8'h73, 8'h05);
      addr = 8'h73; #1; lo = rdata8;
      addr = 8'h74; #1; hi = rdata8;
      chk("R3 8-bit low", 16'(lo), 16'h05);
      chk("R3 8-bit high ignored", 16'(hi), 16'h00);
      wr(8'h73, 8'h00); wr(8'h74, 8'h00);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_regs();
      t_seconds();
      t_minutes();
      t_stop();
      t_events();
      t_ir();
      t_expiry();
      t_force();
      t_w8();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule